// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits over several clock cycles and returns their full `2N`-bit signed product. It scans the multiplier one bit per cycle, always paired with the bit scanned just before it. Each pair tells the block to add the multiplicand into the upper half of a shifting product register, to subtract it, or to leave that half unchanged. An arithmetic right shift by one place follows every decision. The result is a signed product with no separate sign correction pass.

Operands are offered with a one-cycle `go` strobe, and the block accepts them only while `busy` is low. `go` therefore works as a valid signal, and `!busy` is the matching ready. A strobe seen while `busy` is high is dropped: the block captures no operands and starts no new job, so the source has to wait for `busy` to fall before offering the next pair. The output side has no back-pressure. `done` pulses for one cycle, and `product` then holds the result until the block accepts another `go`. The upper half of the product register is kept one bit wider than an operand, so the most negative multiplicand is handled without wrap-around. Carries out of that widened half are dropped.

Top module: `booth_seq_mul`

## Requirements
- R1: When `go` is high and `busy` is low at a rising clock edge, the block captures `mcand` and `mplier`, and `busy` is high from the next cycle.
- R2: An accepted job keeps `busy` high for exactly `N` cycles, one recode-and-shift step per cycle. In the cycle after the last step, `busy` is low and `done` is high.
- R3: `done` is high for a single cycle. After that, `product` keeps its value for as long as no new `go` is accepted.
- R4: A `go` raised while `busy` is high is ignored: the job in flight finishes with its original operands, and no extra `done` pulse appears.
- R5: `product` equals the signed product of `mcand` and `mplier`, both read as two's-complement, for every operand pair.
- R6: Steps follow the pair (current multiplier bit, previously examined bit), where the previous bit starts at 0. The pair 01 adds the multiplicand to the upper half, the pair 10 subtracts it, and the pairs 00 and 11 leave the upper half unchanged. A multiplier of all ones therefore yields the negated multiplicand, and an alternating pattern such as 0101 yields the plain product.
- R7: The most negative multiplicand gives an exact product, for example -8 × -8 = 64 (0x40) and -8 × 7 = -56 (0xC8) for N = 4.
- R8: Carries out of the upper-half add or subtract are discarded, so that 2 × -3 gives 1111_1010 for N = 4.
- R9: After reset, `busy` and `done` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Operand-valid strobe, accepted only while `busy` is low |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | Job in progress; its inverse is the ready for `go` |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 2N | Signed product, held until the next accepted `go` |

## Verification
The bench builds the block with N = 4. This width allows an exhaustive sweep of all 256 operand pairs, so every recoding path is exercised, including -8 on either side and the signed wrap of the upper half. Directed jobs come before the sweep. They cover a multiplier of all ones, an alternating multiplier, a `go` raised in the middle of a job, and a product that must hold over idle cycles. The bench counts `busy` cycles for every job to confirm the N-step latency.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_e;

  // Pair (current bit, previous bit) to the action on the upper half.
  function automatic step_e decode_pair(input logic cur, input logic prev);
    unique case ({cur, prev})
      2'b01:   decode_pair = STEP_ADD;
      2'b10:   decode_pair = STEP_SUB;
      default: decode_pair = STEP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic  cur_bit,
  input  logic  prev_bit,
  output step_e op
);

  always_comb begin
    op = decode_pair(cur_bit, prev_bit);
  end

  // R6: equal bits never touch the upper half, and unequal bits always do
  always_comb begin
    pair_map_chk: assert ((cur_bit == prev_bit) == (op == STEP_HOLD))
      else $error("recoder mapping broken");
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] upper,
  input  logic [W-1:0] mc,
  input  step_e        op,
  output logic [W-1:0] result
);

  // Carry out of the W-bit sum is dropped (wraps modulo 2^W).
  always_comb begin
    unique case (op)
      STEP_ADD: result = upper + mc;
      STEP_SUB: result = upper - mc;
      default:  result = upper;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done,
  output logic load,
  output logic step_en
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] step_cnt;
  logic          last_step;

  assign load      = go && !busy;
  assign step_en   = busy;
  assign last_step = busy && (step_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= last_step;
      if (load) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        step_cnt <= step_cnt + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  // R2
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_cnt == LAST) |=> (done && !busy));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  localparam int HW = N + 1;  // widened upper half

  logic [HW-1:0] hi_q;      // upper half, one guard bit
  logic [N-1:0]  lo_q;      // lower half, starts as multiplier
  logic          prev_q;    // previously examined multiplier bit
  logic [HW-1:0] mc_q;      // sign-extended multiplicand
  logic [HW-1:0] hi_next;
  logic          load;
  logic          step_en;
  step_e         op;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .busy    (busy),
    .done    (done),
    .load    (load),
    .step_en (step_en)
  );

  booth_recoder u_rec (
    .cur_bit  (lo_q[0]),
    .prev_bit (prev_q),
    .op       (op)
  );

  booth_addsub #(.W(HW)) u_as (
    .upper  (hi_q),
    .mc     (mc_q),
    .op     (op),
    .result (hi_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      prev_q <= 1'b0;
      mc_q   <= '0;
    end else if (load) begin
      hi_q   <= '0;
      lo_q   <= mplier;
      prev_q <= 1'b0;
      mc_q   <= {mcand[N-1], mcand};
    end else if (step_en) begin
      // arithmetic shift of {hi, lo, prev} by one place
      hi_q   <= {hi_next[HW-1], hi_next[HW-1:1]};
      lo_q   <= {hi_next[0], lo_q[N-1:1]};
      prev_q <= lo_q[0];
    end
  end

  assign product = {hi_q[N-1:0], lo_q};

  // R4
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mc_q));

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(product));

  // R1
  load_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (hi_q == '0 && !prev_q && lo_q == $past(mplier)));

endmodule

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;

  localparam int N = 4;
  localparam int PW = 2 * N;

  typedef struct {
    logic [PW-1:0] val;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [N-1:0]  mcand = '0;
  logic [N-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int   n_checks = 0;
  int   n_fails = 0;
  exp_t sb_q[$];

  booth_seq_mul #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[PW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", product, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(product == e.val, e.tag, product, e.val);
      end
    end
  end

  // Driver: offer one job, track busy length (R2)
  task automatic run_job(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
    int cyc;
    @(negedge clk);
    while (busy) @(negedge clk);
    go = 1'b1; mcand = a; mplier = b;
    sb_q.push_back('{val: ref_mul(a, b), tag: tag});
    @(negedge clk);
    go = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    check(cyc == N, "R2 busy length", PW'(cyc), PW'(N));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && product == '0, "R9 reset state",
          {6'd0, busy, done} | product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 wrap of the upper half: 2 x -3
    run_job(4'b0010, 4'b1101, "R8 2x-3");
    check(product == 8'hFA, "R8 literal FA", product, 8'hFA);

    // R7 most negative multiplicand
    run_job(4'b1000, 4'b1000, "R7 -8x-8");
    check(product == 8'h40, "R7 literal 40", product, 8'h40);
    run_job(4'b1000, 4'b0111, "R7 -8x7");

    // R6 recoding patterns
    run_job(4'b0101, 4'b1111, "R6 all ones multiplier");
    check(product == 8'hFB, "R6 negated mcand", product, 8'hFB);
    run_job(4'b0011, 4'b0101, "R6 alternating multiplier");

    // R1 / R4: a second go during busy must be ignored
    @(negedge clk);
    go = 1'b1; mcand = 4'd3; mplier = 4'd5;
    sb_q.push_back('{val: 8'd15, tag: "R4 first job"});
    @(negedge clk);
    check(busy, "R1 busy after accept", {7'd0, busy}, 8'd1);
    mcand = 4'd7; mplier = 4'd7;  // go still high, block busy
    @(negedge clk);
    go = 1'b0;
    while (busy) @(negedge clk);
    repeat (N + 3) @(negedge clk);
    check(product == 8'd15, "R4 original operands kept", product, 8'd15);

    // R3 product holds, done is one cycle
    run_job(4'b1110, 4'b0011, "R3 job");
    held = product;
    @(negedge clk);
    check(!done, "R3 done one cycle", {7'd0, done}, 8'd0);
    repeat (4) @(negedge clk);
    check(product == held, "R3 product hold", product, held);

    // R5 exhaustive sweep
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        run_job(N'(i), N'(j), "R5 sweep");
      end
    end
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R4 no missing results", PW'(sb_q.size()), '0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule